// File: doc/BRIEF.md
# Serial Management Register Target

This block is a target on a two-wire management bus. The bus has a clock driven by the controller and one bidirectional data line. Through the bus, an external controller reads and writes a bank of 8-bit configuration registers.

The frame follows the usual management-frame shape, with these differences:

- The 2-bit opcode must be 00.
- Bit 4 of the 5-bit device-address field picks the direction.
- The low three bits of the device-address field and the five register-address bits join into an 8-bit register address.
- Only the low byte of the 16-bit data field is meaningful.

The block takes bits on the rising clock edge. It changes what it drives only after the falling edge. It drives the line only during the second turnaround bit and the data bits of a read.

On the register side, the block presents a plain register-file port. The port has an address, a read-data input sampled once per read, and a one-cycle write strobe with write data. The bank behind the port is not part of the block. The block gates every access against the last valid register index.

Top module: `mgmt_reg_target`

## Requirements
- R1: A frame is recognised only after at least PRE_LEN (32) consecutive ones followed by the start bits 0 then 1. A run of only 31 ones before the start bits makes the frame be ignored, with no drive and no write. A longer run of ones is accepted.
- R2: Only the opcode 00 (the two bits after the start bits) yields an access. Any other opcode makes the rest of the frame be ignored, with mdio_oe low and no rf_we. The next valid frame is then served normally.
- R3: Bit 4 of the device-address field (the first address bit sent) selects the direction: 1 is a read and 0 is a write. Bit 3 of that field has no effect on the access.
- R4: The register address on rf_addr is {device-address bits [2:0], register-address bits [4:0]}, each field sent most significant bit first.
- R5: In a write, the controller sends the two turnaround bits 1,0 and then 16 data bits, MSB first. One cycle after the last data bit is taken, rf_we is high for exactly one cycle, and rf_wdata carries the low 8 data bits. The upper 8 data bits are ignored.
- R6: In a read, the line is left undriven (mdio_oe low) during the first turnaround bit. The target drives 0 during the second turnaround bit.
- R7: In a read, the target then drives 16 bits, MSB first. The upper 8 bits are zero, and the lower 8 bits are rf_rdata for the addressed register.
- R8: Addresses above LAST_REG (0xC6) read as zero, and writes to them produce no rf_we. The address 0xC6 itself is accessed normally.
- R9: mdio_oe is low during reset, between frames and during every controller-driven bit. It drops after the falling edge that follows the last read data bit. It never stays high for more than 17 bit times.
- R10: A wrong start pattern (0 then 0) after the preamble is ignored, with no drive and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Resolved level of the data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line (1 = drive) |
| rf_addr | output | 8 | Register address of the current access |
| rf_rdata | input | 8 | Read data from the register bank for rf_addr |
| rf_we | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Data to write |

## Verification
The bench builds the block with the default parameters: PRE_LEN of 32 and LAST_REG of 0xC6. With these values, the bench can compare a 31-one preamble against a 32-one preamble and a longer one. The bench also reaches the exact register-range edge, comparing 0xC6 against 0xC7 and 0xFF. Its register model returns non-zero values above the range, so a missing range gate shows up in the read data. It also counts write strobes, so a discarded write can be seen at the ports.

// File: rtl/mgmt_reg_target.sv
module mgmt_reg_target #(
  parameter int          PRE_LEN  = 32,
  parameter logic [7:0]  LAST_REG = 8'hC6
) (
  input  logic       mdc,
  input  logic       rst_n,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic [7:0] rf_addr,
  input  logic [7:0] rf_rdata,
  output logic       rf_we,
  output logic [7:0] rf_wdata
);
  localparam int HDR_BITS = 12;
  localparam int DATA_BITS = 16;
  localparam int RD_BITS = DATA_BITS + 1;
  localparam int WR_BITS = DATA_BITS + 2;
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam int NW = $clog2(WR_BITS);

  typedef enum logic [2:0] {S_HUNT, S_SOF, S_HDR, S_RDTA, S_RDDAT, S_WR} st_t;

  st_t             st;
  logic [CW-1:0]   ones;
  logic [NW-1:0]   cnt;
  logic [11:0]     hdr;
  logic [RD_BITS-1:0] rsh;
  logic [6:0]      wsh;
  logic [7:0]      addr;

  wire [11:0] hdr_n    = {hdr[10:0], mdio_i};
  wire        in_range = (addr <= LAST_REG);

  assign rf_addr = addr;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HUNT;
      ones     <= '0;
      cnt      <= '0;
      hdr      <= '0;
      rsh      <= '0;
      wsh      <= '0;
      addr     <= '0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_we <= 1'b0;
      case (st)
        S_HUNT: begin
          if (mdio_i) begin
            if (ones != CW'(PRE_LEN)) ones <= ones + CW'(1);
          end else if (ones == CW'(PRE_LEN)) begin
            st <= S_SOF;
          end else begin
            ones <= '0;
          end
        end
        S_SOF: begin
          ones <= '0;
          if (mdio_i) begin
            st  <= S_HDR;
            cnt <= '0;
          end else begin
            st <= S_HUNT;
          end
        end
        S_HDR: begin
          hdr <= hdr_n;
          if (cnt == NW'(HDR_BITS - 1)) begin
            cnt <= '0;
            if (hdr_n[11:10] != 2'b00) begin
              st <= S_HUNT;
            end else begin
              addr <= hdr_n[7:0];
              st   <= hdr_n[9] ? S_RDTA : S_WR;
            end
          end else begin
            cnt <= cnt + NW'(1);
          end
        end
        S_RDTA: begin
          rsh <= {9'b0, in_range ? rf_rdata : 8'h00};
          cnt <= '0;
          st  <= S_RDDAT;
        end
        S_RDDAT: begin
          if (cnt == NW'(RD_BITS - 1)) begin
            st   <= S_HUNT;
            ones <= '0;
          end else begin
            cnt <= cnt + NW'(1);
            rsh <= {rsh[RD_BITS-2:0], 1'b0};
          end
        end
        S_WR: begin
          wsh <= {wsh[5:0], mdio_i};
          if (cnt == NW'(WR_BITS - 1)) begin
            rf_we    <= in_range;
            rf_wdata <= {wsh, mdio_i};
            st       <= S_HUNT;
            ones     <= '0;
          end else begin
            cnt <= cnt + NW'(1);
          end
        end
        default: st <= S_HUNT;
      endcase
    end
  end

  always_ff @(negedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
    end else begin
      mdio_oe <= (st == S_RDDAT);
      mdio_o  <= (st == S_RDDAT) & rsh[RD_BITS-1];
    end
  end
endmodule

module mgmt_reg_target_chk #(
  parameter logic [7:0] LAST_REG = 8'hC6
) (
  input logic       mdc,
  input logic       rst_n,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       rf_we,
  input logic [7:0] rf_addr
);
  logic [4:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= mdio_oe ? oe_run + 5'd1 : 5'd0;
  end

  a_r5_we_single: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |=> !rf_we);
  a_r8_we_in_range: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |-> (rf_addr <= LAST_REG));
  a_r6_ta_low: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  a_r7_upper_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    (mdio_oe && oe_run < 5'd9) |-> !mdio_o);
  a_r9_oe_bounded: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (oe_run < 5'd17));
  a_r3_no_we_in_read: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> !rf_we);
endmodule

bind mgmt_reg_target mgmt_reg_target_chk #(.LAST_REG(LAST_REG)) u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .rf_we(rf_we), .rf_addr(rf_addr)
);

// File: tb/mgmt_reg_target_bench.sv
`timescale 1ns/1ps
module mgmt_reg_target_bench;
  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_en = 1'b0;
  logic       ctl_val = 1'b1;
  logic       mdio_o, mdio_oe, rf_we;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  wire        line = mdio_oe ? mdio_o : (ctl_en ? ctl_val : 1'b1);

  logic [7:0] mem [256];
  int         we_cnt = 0;
  logic [7:0] last_waddr = '0, last_wdata = '0;
  int         vectors = 0, fails = 0, cyc = 0;
  logic       s_oe, s_o, saw_oe, done = 1'b0;

  always #2 mdc = ~mdc;

  mgmt_reg_target u_mgmt_reg_target (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  assign rf_rdata = mem[rf_addr];

  always @(posedge mdc) begin
    cyc = cyc + 1;
    if (rst_n && rf_we) begin
      mem[rf_addr] = rf_wdata;
      we_cnt = we_cnt + 1;
      last_waddr = rf_addr;
      last_wdata = rf_wdata;
    end
    if (cyc > 50000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic v);
    @(negedge mdc);
    #1 ctl_en = en; ctl_val = v;
    @(posedge mdc);
    #1 s_oe = mdio_oe; s_o = mdio_o;
    if (s_oe) saw_oe = 1'b1;
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] sof, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] rg);
    for (int i = 0; i < pre; i++) tick(1'b1, 1'b1);
    for (int i = 1; i >= 0; i--) tick(1'b1, sof[i]);
    for (int i = 1; i >= 0; i--) tick(1'b1, op[i]);
    for (int i = 4; i >= 0; i--) tick(1'b1, phy[i]);
    for (int i = 4; i >= 0; i--) tick(1'b1, rg[i]);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input string tag);
    int w0;
    w0 = we_cnt;
    send_hdr(32, 2'b01, 2'b00, phy, rg);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) tick(1'b1, d[i]);
    tick(1'b0, 1'b1);
    check(we_cnt == w0 + 1, {tag, " write strobe count"}, we_cnt - w0, 1);
    check(last_wdata == d[7:0], {tag, " write data low byte"}, last_wdata, d[7:0]);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] exp, input string tag);
    logic [15:0] got;
    saw_oe = 1'b0;
    send_hdr(32, 2'b01, 2'b00, phy, rg);
    check(!saw_oe, "R9 no drive during header", saw_oe, 0);
    tick(1'b0, 1'b1);
    check(!s_oe, "R6 first turnaround undriven", s_oe, 0);
    tick(1'b0, 1'b1);
    check(s_oe && !s_o, "R6 second turnaround driven 0", {s_oe, s_o}, 2'b10);
    for (int i = 15; i >= 0; i--) begin
      tick(1'b0, 1'b1);
      got[i] = s_oe ? s_o : 1'bx;
    end
    check(got === exp, tag, got, exp);
    tick(1'b0, 1'b1);
    check(!s_oe, "R9 released after last data bit", s_oe, 0);
  endtask

  task automatic ignored_frame(input int pre, input logic [1:0] sof, input logic [1:0] op,
                               input logic [4:0] phy, input logic [4:0] rg, input string tag);
    int w0;
    w0 = we_cnt;
    saw_oe = 1'b0;
    tick(1'b1, 1'b0);
    send_hdr(pre, sof, op, phy, rg);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) tick(1'b1, 1'b1);
    check(!saw_oe, {tag, " no drive"}, saw_oe, 0);
    check(we_cnt == w0, {tag, " no write"}, we_cnt - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(posedge mdc);
    #1 check(!mdio_oe && !rf_we, "R9 reset state idle", {mdio_oe, rf_we}, 0);
    rst_n = 1'b1;

    do_write(5'b00011, 5'b00101, 16'hAB3C, "R5 R4");
    check(last_waddr == 8'h65, "R4 write address", last_waddr, 8'h65);
    do_read(5'b11011, 5'b00101, 16'h003C, "R7 R3 read back with bit3 set");

    do_write(5'b01110, 5'b00001, 16'h00E7, "R3 write with bit3 set");
    check(last_waddr == 8'hC1, "R3 write address with bit3 set", last_waddr, 8'hC1);
    do_read(5'b10110, 5'b00001, 16'h00E7, "R3 read with bit3 clear");

    do_read(5'b10110, 5'b00110, 16'h009C, "R8 last valid register 0xC6");
    do_read(5'b10110, 5'b00111, 16'h0000, "R8 read 0xC7 is zero");
    do_read(5'b10111, 5'b11111, 16'h0000, "R8 read 0xFF is zero");

    begin
      int w0;
      w0 = we_cnt;
      send_hdr(32, 2'b01, 2'b00, 5'b00111, 5'b11111);
      tick(1'b1, 1'b1);
      tick(1'b1, 1'b0);
      for (int i = 0; i < 16; i++) tick(1'b1, 1'b1);
      tick(1'b0, 1'b1);
      check(we_cnt == w0, "R8 write to 0xFF discarded", we_cnt - w0, 0);
    end
    do_read(5'b10111, 5'b11111, 16'h0000, "R8 read 0xFF after discarded write");

    ignored_frame(32, 2'b01, 2'b01, 5'b00011, 5'b00101, "R2 opcode 01");
    ignored_frame(32, 2'b01, 2'b10, 5'b10011, 5'b00101, "R2 opcode 10 read");
    do_read(5'b10011, 5'b00101, 16'h003C, "R2 resync after bad opcode");

    ignored_frame(31, 2'b01, 2'b00, 5'b10011, 5'b00101, "R1 31-one preamble");
    ignored_frame(31, 2'b01, 2'b00, 5'b00011, 5'b00101, "R1 31-one preamble write");
    do_read(5'b10011, 5'b00101, 16'h003C, "R1 data kept after short preamble");

    ignored_frame(32, 2'b00, 2'b00, 5'b10011, 5'b00101, "R10 start 00");
    do_read(5'b10000, 5'b00010, 16'h0058, "R10 resync after bad start");

    tick(1'b1, 1'b0);
    saw_oe = 1'b0;
    send_hdr(48, 2'b01, 2'b00, 5'b10011, 5'b00101);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    check(s_oe && !s_o, "R1 long preamble accepted", {s_oe, s_o}, 2'b10);
    for (int i = 0; i < 17; i++) tick(1'b0, 1'b1);
    check(!s_oe, "R9 idle after long-preamble read", s_oe, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule